// File: doc/BRIEF.md
# Optional Barrel Shift Unit

This block is the barrel shifter of a small 32-bit RISC core's execute stage. It looks at the 6-bit major opcode and decides whether the instruction is a barrel shift. It accepts two forms: one where the shift amount comes from a register, and one where it comes from a sign-extended immediate. For a shift, it reads the direction and type from two bits of a subfunction field taken from the instruction. It then shifts operand A by the low five bits of operand B, all within the same cycle.

The shifter is optional. When the enable parameter is 0, no shift datapath is built. A barrel-shift opcode is then reported as an illegal encoding, so the core can trap it. Operand fetch, forwarding, stalls and write-back belong to the surrounding pipeline.

Top module: `bshift_unit`

## Requirements
- R1: Opcode 6'o21 (register form) with the unit enabled asserts valid_o and shifts opa_i by opb_i[4:0]; opb_i[31:5] has no effect on the result.
- R2: Opcode 6'o31 (immediate form) behaves exactly like opcode 6'o21 for the same operands and subfunction.
- R3: Subfunction bits func_i[10:9] = 2'd0 give a logical right shift that fills vacated bits with zeros.
- R4: func_i[10:9] = 2'd1 gives an arithmetic right shift that fills vacated bits with opa_i[31].
- R5: func_i[10:9] = 2'd2 gives a left shift that fills vacated bits with zeros.
- R6: func_i[10:9] = 2'd3 on a barrel-shift opcode raises illegal_o, keeps valid_o low and drives result_o to 0.
- R7: A shift amount of 0 returns opa_i unchanged for every legal shift type.
- R8: Any opcode other than 6'o21 and 6'o31 leaves valid_o and illegal_o low and result_o at 0.
- R9: Bits of func_i other than 10:9 have no effect on any output.
- R10: With the enable parameter at 0, a barrel-shift opcode raises illegal_o, keeps valid_o low and drives result_o to 0, whatever the subfunction.
- R11: The outputs follow the inputs within the same cycle; no register lies on the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opcode_i | input | 6 | Major opcode of the instruction in execute |
| func_i | input | 11 | Subfunction field; bits 10:9 pick the shift type |
| opa_i | input | 32 | Value to be shifted |
| opb_i | input | 32 | Register value or sign-extended immediate; bits 4:0 give the amount |
| result_o | output | 32 | Shifted value, 0 unless valid_o is high |
| valid_o | output | 1 | High for a legal barrel-shift instruction |
| illegal_o | output | 1 | High for a barrel-shift opcode that cannot be executed |

## Verification
The bench builds two copies of the block at the default 32-bit width: one with the shifter enabled and one with it disabled. Because the datapath is small, the enabled copy can be swept over every shift amount, every subfunction code, both opcode forms and a set of edge-heavy operand patterns. That sweep reaches the full-width fill cases in both directions. The disabled copy, together with a sweep over all 64 opcodes, covers the trap path and the rejection of instructions that are not shifts.

// File: rtl/bshift_pkg.sv
package bshift_pkg;
  localparam logic [5:0] OPC_BS_REG = 6'o21;
  localparam logic [5:0] OPC_BS_IMM = 6'o31;
  localparam int FUNC_W  = 11;
  localparam int KIND_LO = 9;

  typedef enum logic [1:0] {
    SH_RIGHT_LOG = 2'd0,
    SH_RIGHT_ARI = 2'd1,
    SH_LEFT_LOG  = 2'd2,
    SH_RESERVED  = 2'd3
  } sh_kind_e;
endpackage

// File: rtl/bshift_decode.sv
module bshift_decode
  import bshift_pkg::*;
#(
  parameter bit ENABLE = 1'b1
) (
  input  logic [5:0]        opcode_i,
  input  logic [FUNC_W-1:0] func_i,
  output sh_kind_e          kind_o,
  output logic              go_o,
  output logic              illegal_o
);
  logic is_bs;
  sh_kind_e kind;

  always_comb begin
    is_bs = (opcode_i == OPC_BS_REG) || (opcode_i == OPC_BS_IMM);
    kind  = sh_kind_e'(func_i[KIND_LO+1:KIND_LO]);
    kind_o = kind;
    if (ENABLE) begin
      go_o      = is_bs && (kind != SH_RESERVED);
      illegal_o = is_bs && (kind == SH_RESERVED);
    end else begin
      go_o      = 1'b0;
      illegal_o = is_bs;
    end
  end

  always_comb begin
    assert_go_illegal_excl_R6: assert (!(go_o && illegal_o))
      else $error("go and illegal both high");
  end
endmodule

// File: rtl/bshift_core.sv
module bshift_core #(
  parameter int DATA_W = 32,
  localparam int SH_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [SH_W-1:0]   amt_i,
  input  logic              left_i,
  input  logic              arith_i,
  output logic [DATA_W-1:0] data_o
);
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] rev_out;
  logic [DATA_W-1:0] stage_in;
  logic [DATA_W-1:0] stg [SH_W+1];
  logic              fill;

  // left shift reuses the right-shift network on bit-reversed data
  for (genvar b = 0; b < DATA_W; b++) begin : g_rev
    assign rev_in[b]  = data_i[DATA_W-1-b];
    assign rev_out[b] = stg[SH_W][DATA_W-1-b];
  end

  assign stage_in = left_i ? rev_in : data_i;
  assign fill     = arith_i & ~left_i & data_i[DATA_W-1];
  assign stg[0]   = stage_in;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int STEP = 1 << k;
    assign stg[k+1] = amt_i[k] ? {{STEP{fill}}, stg[k][DATA_W-1:STEP]} : stg[k];
  end

  assign data_o = left_i ? rev_out : stg[SH_W];

  always_comb begin
    assert_zero_amt_pass_R7: assert (amt_i != '0 || data_o == data_i)
      else $error("zero shift altered data");
    assert_arith_fill_R4: assert (!(arith_i && !left_i && amt_i != '0)
                                  || data_o[DATA_W-1] == data_i[DATA_W-1])
      else $error("arithmetic fill wrong");
  end
endmodule

// File: rtl/bshift_unit.sv
module bshift_unit
  import bshift_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter bit ENABLE   = 1'b1,
  localparam int SH_W    = $clog2(DATA_W)
) (
  input  logic [5:0]        opcode_i,
  input  logic [10:0]       func_i,
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  output logic [DATA_W-1:0] result_o,
  output logic              valid_o,
  output logic              illegal_o
);
  sh_kind_e kind;
  logic     go;

  bshift_decode #(.ENABLE(ENABLE)) u_dec (
    .opcode_i (opcode_i),
    .func_i   (func_i),
    .kind_o   (kind),
    .go_o     (go),
    .illegal_o(illegal_o)
  );

  if (ENABLE) begin : g_on
    logic [DATA_W-1:0] shifted;
    bshift_core #(.DATA_W(DATA_W)) u_core (
      .data_i (opa_i),
      .amt_i  (opb_i[SH_W-1:0]),
      .left_i (kind == SH_LEFT_LOG),
      .arith_i(kind == SH_RIGHT_ARI),
      .data_o (shifted)
    );
    assign result_o = go ? shifted : '0;
  end else begin : g_off
    logic unused_b;
    assign unused_b = ^{opa_i, opb_i, kind};
    assign result_o = '0;
  end

  assign valid_o = go;

  always_comb begin
    assert_idle_zero_R8: assert (valid_o || result_o == '0)
      else $error("result nonzero while not valid");
    assert_disabled_never_valid_R10: assert (ENABLE || !valid_o)
      else $error("valid with shifter absent");
    assert_nonshift_quiet_R8: assert (opcode_i == OPC_BS_REG || opcode_i == OPC_BS_IMM
                                      || (!valid_o && !illegal_o))
      else $error("non-shift opcode flagged");
  end
endmodule

// File: tb/bshift_unit_test.sv
module bshift_unit_test;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [5:0]  opcode;
  logic [10:0] func;
  logic [31:0] opa, opb;
  logic [31:0] res_on, res_off;
  logic        val_on, val_off, ill_on, ill_off;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  bshift_unit #(.DATA_W(32), .ENABLE(1'b1)) uut (
    .opcode_i(opcode), .func_i(func), .opa_i(opa), .opb_i(opb),
    .result_o(res_on), .valid_o(val_on), .illegal_o(ill_on));

  bshift_unit #(.DATA_W(32), .ENABLE(1'b0)) uut_off (
    .opcode_i(opcode), .func_i(func), .opa_i(opa), .opb_i(opb),
    .result_o(res_off), .valid_o(val_off), .illegal_o(ill_off));

  task automatic chk(string req, logic [33:0] act, logic [33:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h (opc=%o func=%h a=%h b=%h)",
               req, act, exp, opcode, func, opa, opb);
    end
  endtask

  function automatic logic [31:0] model(logic [1:0] k, logic [31:0] a, logic [4:0] s);
    case (k)
      2'd0: return a >> s;
      2'd1: return 32'($signed(a) >>> s);
      2'd2: return a << s;
      default: return 32'h0;
    endcase
  endfunction

  task automatic apply(logic [5:0] o, logic [10:0] f, logic [31:0] a, logic [31:0] b);
    @(negedge clk);
    opcode = o; func = f; opa = a; opb = b;
    #1;
  endtask

  logic [31:0] pats [6] = '{32'h0000_0001, 32'h8000_0000, 32'hFFFF_FFFF,
                            32'h7FFF_FFFF, 32'hA5C3_0F96, 32'h1234_5678};

  initial begin
    opcode = 6'o00; func = '0; opa = '0; opb = '0;
    #1;
    // reset-like idle state
    chk("R8 idle", {res_on, val_on, ill_on}, 34'h0);

    for (int oi = 0; oi < 2; oi++) begin
      for (int k = 0; k < 3; k++) begin
        for (int p = 0; p < 6; p++) begin
          for (int s = 0; s < 32; s++) begin
            logic [5:0] o;
            logic [31:0] e;
            o = oi ? 6'o31 : 6'o21;
            e = model(2'(k), pats[p], 5'(s));
            // upper opb bits and other func bits are noise
            apply(o, {2'(k), 9'(p * 37 + s)}, pats[p], {27'(s * 999 + p), 5'(s)});
            case (k)
              0: chk(oi ? "R2 R3 lsr" : "R1 R3 lsr", {res_on, val_on, ill_on}, {e, 2'b10});
              1: chk(oi ? "R2 R4 asr" : "R1 R4 asr", {res_on, val_on, ill_on}, {e, 2'b10});
              default: chk(oi ? "R2 R5 lsl" : "R1 R5 lsl", {res_on, val_on, ill_on}, {e, 2'b10});
            endcase
            if (s == 0) chk("R7 pass", {res_on, 2'b00}, {pats[p], 2'b00});
            chk("R10 off", {res_off, val_off, ill_off}, {32'h0, 2'b01});
          end
        end
      end
    end

    // R9: other func bits do not change anything
    for (int f = 0; f < 512; f += 17) begin
      apply(6'o21, {2'd1, 9'(f)}, 32'h9000_00F0, 32'h0000_0004);
      chk("R9 func", {res_on, val_on, ill_on}, {32'hF900_000F, 2'b10});
    end

    // R6 reserved subfunction
    for (int oi = 0; oi < 2; oi++) begin
      for (int p = 0; p < 6; p++) begin
        apply(oi ? 6'o31 : 6'o21, {2'd3, 9'(p)}, pats[p], 32'h3);
        chk("R6 reserved", {res_on, val_on, ill_on}, {32'h0, 2'b01});
        chk("R10 reserved", {res_off, val_off, ill_off}, {32'h0, 2'b01});
      end
    end

    // R8 all other opcodes
    for (int o = 0; o < 64; o++) begin
      if (o != 'o21 && o != 'o31) begin
        apply(6'(o), {2'd2, 9'h1FF}, 32'hDEAD_BEEF, 32'h5);
        chk("R8 other", {res_on, val_on, ill_on}, 34'h0);
        chk("R8 other off", {res_off, val_off, ill_off}, 34'h0);
      end
    end

    // R11 same-cycle: change inputs mid-cycle, no clock edge in between
    @(posedge clk); #0.5;
    opcode = 6'o21; func = {2'd2, 9'h0}; opa = 32'h1; opb = 32'd31;
    #0.5;
    chk("R11 comb", {res_on, val_on, ill_on}, {32'h8000_0000, 2'b10});
    opa = 32'h3; #0.5;
    chk("R11 comb", {res_on, val_on, ill_on}, {32'h8000_0000, 2'b10});
    opb = 32'd30; #0.5;
    chk("R11 comb", {res_on, val_on, ill_on}, {32'hC000_0000, 2'b10});

    done = 1;
  end

  initial begin
    for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog act=running exp=done");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule